// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column address order for a single memory burst. A one-cycle start strobe loads a column address together with a length select (4 or 8 beats) and an order select (sequential or interleaved). From the next clock on, the block presents one column address per cycle, flagged valid, and marks the final beat with a last flag.

Only the column bits inside the burst window are reordered: the two lowest bits for a 4-beat burst and the three lowest for an 8-beat burst. Every bit above the window is copied unchanged from the loaded address on every beat. In sequential order the window offset counts up from the start offset and wraps inside the window. In interleaved order, beat i uses the start offset XORed with i.

A start that arrives while a burst is still running is dropped. A start in the cycle that shows the last beat is taken, so consecutive bursts can follow with no idle cycle between them. The block issues no commands and does no timing or data handling.

Top module: `burst_col_seq`

## Requirements
- R1: While rst_ni is low, and after it rises until the first accepted start, valid_o and last_o are 0.
- R2: An accepted start at a clock edge makes valid_o 1 after that same edge, and col_o then equals the col_i sampled at that edge exactly.
- R3: With bl8_i=0 and bt_i=0, beat i has col_o[1:0] = (s + i) mod 4, where s is the loaded col_i[1:0]; for example s=1 gives 1,2,3,0 and s=2 gives 2,3,0,1.
- R4: With bl8_i=1 and bt_i=0, beat i has col_o[2:0] = (s + i) mod 8, where s is the loaded col_i[2:0]; for example s=5 gives 5,6,7,0,1,2,3,4.
- R5: With bl8_i=0 and bt_i=1, beat i has col_o[1:0] = s XOR i; for example s=1 gives 1,0,3,2 and s=3 gives 3,2,1,0.
- R6: With bl8_i=1 and bt_i=1, beat i has col_o[2:0] = s XOR i; for example s=6 gives 6,7,4,5,2,3,0,1 and s=5 gives 5,4,7,6,1,0,3,2.
- R7: In a 4-beat burst, col_i[2] and the bits above it do not change the order, and col_o[2] keeps the loaded value on every beat.
- R8: Every column bit above the burst window equals the loaded col_i on every beat of the burst.
- R9: valid_o stays 1 for exactly 4 (bl8_i=0) or 8 (bl8_i=1) consecutive cycles per burst, and last_o is 1 on the final beat only.
- R10: A start_i that arrives while valid_o=1 and last_o=0 is ignored: the running burst continues unchanged.
- R11: A start_i in a cycle where last_o=1 is accepted, so the next burst's first beat follows the last beat in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe for a new burst |
| col_i | input | COL_W | Start column address |
| bl8_i | input | 1 | Length select: 0 = 4 beats, 1 = 8 beats |
| bt_i | input | 1 | Order select: 0 = sequential, 1 = interleaved |
| col_o | output | COL_W | Column address of the current beat |
| valid_o | output | 1 | A beat is presented |
| last_o | output | 1 | The current beat is the final one of the burst |

## Verification
The final beat of one burst and the acceptance of the next start can happen in the same cycle, because the controller treats the last-beat cycle as free. The bench provokes this by raising start_i exactly when its model predicts that the last beat is on the outputs. It does this in a directed case and also at random in a long mixed run. The model then expects the new burst's first address in the following cycle with no idle cycle, and in the other case it expects a dropped start while the burst is mid-flight. Both outcomes are compared with the outputs every clock.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic {
    ORD_SEQ = 1'b0,
    ORD_IL  = 1'b1
  } ord_e;
endpackage

// File: rtl/burst_seq_order.sv
module burst_seq_order #(
  parameter int LONG_LOG2  = 3,
  parameter int SHORT_LOG2 = 2
) (
  input  logic [LONG_LOG2-1:0] start_i,
  input  logic [LONG_LOG2-1:0] beat_i,
  input  logic                 long_i,
  input  logic                 il_i,
  output logic [LONG_LOG2-1:0] off_o
);
  localparam int LW = LONG_LOG2;
  localparam int SW = SHORT_LOG2;

  logic [LW-1:0] sum;
  assign sum = start_i + beat_i;

  // low bits of the full sum equal the sum modulo the window size
  for (genvar b = 0; b < LW; b++) begin : g_bit
    logic in_win;
    if (b < SW) begin : g_short
      assign in_win = 1'b1;
    end else begin : g_long
      assign in_win = long_i;
    end
    assign off_o[b] = !in_win ? start_i[b]
                    : il_i    ? (start_i[b] ^ beat_i[b])
                    :           sum[b];
  end
endmodule

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl #(
  parameter int LONG_LOG2  = 3,
  parameter int SHORT_LOG2 = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic                 bl8_i,
  output logic                 load_o,
  output logic                 adv_o,
  output logic [LONG_LOG2-1:0] beat_o,
  output logic                 long_nxt_o,
  output logic                 long_o,
  output logic                 valid_o,
  output logic                 last_o
);
  localparam int LW = LONG_LOG2;
  localparam logic [LW-1:0] LONG_END  = LW'((1 << LONG_LOG2) - 1);
  localparam logic [LW-1:0] SHORT_END = LW'((1 << SHORT_LOG2) - 1);

  logic [LW-1:0] beat_q;
  logic          long_q, valid_q, last_q;
  logic          busy, last_nxt;

  assign busy       = valid_q && !last_q;
  assign load_o     = start_i && !busy;
  assign adv_o      = busy;
  assign beat_o     = load_o ? '0 : beat_q + LW'(1);
  assign long_nxt_o = load_o ? bl8_i : long_q;
  assign last_nxt   = beat_o == (long_nxt_o ? LONG_END : SHORT_END);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      beat_q  <= '0;
      long_q  <= 1'b0;
      valid_q <= 1'b0;
      last_q  <= 1'b0;
    end else if (load_o || adv_o) begin
      beat_q  <= beat_o;
      long_q  <= long_nxt_o;
      valid_q <= 1'b1;
      last_q  <= last_nxt;
    end else begin
      valid_q <= 1'b0;
      last_q  <= 1'b0;
    end
  end

  assign long_o  = long_q;
  assign valid_o = valid_q;
  assign last_o  = last_q;

  assert_last_in_valid_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_q |-> valid_q);
  assert_last_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_q |=> !last_q);
  assert_no_early_end_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && !last_q) |=> valid_q);
  assert_end_after_last_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_q && !start_i) |=> !valid_q);
  assert_back_to_back_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_q && start_i) |=> (valid_q && !last_q));
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import burst_seq_pkg::*;
#(
  parameter int COL_W      = 10,
  parameter int LONG_LOG2  = 3,
  parameter int SHORT_LOG2 = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [COL_W-1:0] col_i,
  input  logic             bl8_i,
  input  logic             bt_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o
);
  localparam int LW = LONG_LOG2;
  localparam int SW = SHORT_LOG2;

  logic             load, adv, long_nxt, long_q, il_nxt;
  logic [LW-1:0]    beat, off;
  logic [COL_W-1:0] base_q, base_nxt, col_q;
  ord_e             ord_q;

  burst_seq_ctrl #(.LONG_LOG2(LONG_LOG2), .SHORT_LOG2(SHORT_LOG2)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .bl8_i      (bl8_i),
    .load_o     (load),
    .adv_o      (adv),
    .beat_o     (beat),
    .long_nxt_o (long_nxt),
    .long_o     (long_q),
    .valid_o    (valid_o),
    .last_o     (last_o)
  );

  assign base_nxt = load ? col_i : base_q;
  assign il_nxt   = load ? bt_i  : (ord_q == ORD_IL);

  burst_seq_order #(.LONG_LOG2(LONG_LOG2), .SHORT_LOG2(SHORT_LOG2)) u_order (
    .start_i (base_nxt[LW-1:0]),
    .beat_i  (beat),
    .long_i  (long_nxt),
    .il_i    (il_nxt),
    .off_o   (off)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      ord_q  <= ORD_SEQ;
      col_q  <= '0;
    end else begin
      if (load) begin
        base_q <= col_i;
        ord_q  <= bt_i ? ORD_IL : ORD_SEQ;
      end
      if (load || adv) col_q <= {base_nxt[COL_W-1:LW], off};
    end
  end

  assign col_o = col_q;

  assert_first_beat_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !(valid_o && !last_o)) |=> (valid_o && col_o == $past(col_i)));
  assert_upper_stable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !last_o) |=> (col_o[COL_W-1:LW] == $past(col_o[COL_W-1:LW])));
  assert_short_window_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !last_o && !long_q) |=> (col_o[LW-1:SW] == $past(col_o[LW-1:SW])));
  assert_seq_step_short_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !last_o && !long_q && ord_q == ORD_SEQ)
      |=> (col_o[SW-1:0] == $past(col_o[SW-1:0]) + SW'(1)));
  assert_seq_step_long_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !last_o && long_q && ord_q == ORD_SEQ)
      |=> (col_o[LW-1:0] == $past(col_o[LW-1:0]) + LW'(1)));
endmodule

// File: tb/burst_col_seq_tb.sv
module burst_col_seq_tb_top;
  localparam int COL_W = 10;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             start_i = 1'b0;
  logic [COL_W-1:0] col_i = '0;
  logic             bl8_i = 1'b0;
  logic             bt_i = 1'b0;
  logic [COL_W-1:0] col_o;
  logic             valid_o, last_o;

  always #4 clk = ~clk;

  burst_col_seq #(.COL_W(COL_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .col_i(col_i),
    .bl8_i(bl8_i), .bt_i(bt_i), .col_o(col_o), .valid_o(valid_o), .last_o(last_o)
  );

  int vectors = 0;
  int errors = 0;
  bit done = 1'b0;

  // model of what the outputs show after the coming edge
  bit               m_v = 1'b0, m_last = 1'b0;
  logic [COL_W-1:0] m_col = '0;
  string            m_tag = "R1 reset";
  logic [COL_W-1:0] qc[$];
  bit               ql[$];
  string            qt[$];

  task automatic check();
    vectors++;
    if (valid_o !== m_v || last_o !== m_last || (m_v && col_o !== m_col)) begin
      errors++;
      $display("FAIL %s: got v=%b l=%b col=%h exp v=%b l=%b col=%h",
               m_tag, valid_o, last_o, col_o, m_v, m_last, m_col);
    end
  endtask

  task automatic fill(logic [COL_W-1:0] c, bit l8, bit il, string ctx);
    int n = l8 ? 8 : 4;
    int mask = n - 1;
    int s = int'(c) & mask;
    string mode = l8 ? (il ? "R6" : "R4") : (il ? "R5" : "R3");
    for (int i = 0; i < n; i++) begin
      int off = il ? (s ^ i) : ((s + i) & mask);
      qc.push_back((c & ~COL_W'(mask)) | COL_W'(off));
      ql.push_back(i == n - 1);
      qt.push_back(i == 0 ? {ctx, " R2"} : {ctx, " ", mode, " R8 R9"});
    end
  endtask

  task automatic step(bit s, logic [COL_W-1:0] c, bit l8, bit il, string ctx);
    @(negedge clk);
    check();
    start_i = s; col_i = c; bl8_i = l8; bt_i = il;
    if (m_v && !m_last) begin
      m_col = qc.pop_front(); m_last = ql.pop_front(); m_tag = qt.pop_front();
    end else if (s) begin
      fill(c, l8, il, ctx);
      m_v = 1'b1;
      m_col = qc.pop_front(); m_last = ql.pop_front(); m_tag = qt.pop_front();
    end else begin
      m_v = 1'b0; m_last = 1'b0; m_tag = {ctx, " R9 idle"};
    end
  endtask

  task automatic idle(string ctx);
    step(1'b0, '0, 1'b0, 1'b0, ctx);
  endtask

  task automatic burst(logic [COL_W-1:0] c, bit l8, bit il, string ctx);
    step(1'b1, c, l8, il, ctx);
    while (m_v) idle(ctx);
    idle(ctx);
  endtask

  initial begin
    repeat (3) idle("R1");
    @(negedge clk);
    rst_ni = 1'b1;
    repeat (2) idle("R1");
    // directed orders
    burst(10'h001, 1'b0, 1'b0, "R3");
    burst(10'h002, 1'b0, 1'b0, "R3");
    burst(10'h001, 1'b0, 1'b1, "R5");
    burst(10'h003, 1'b0, 1'b1, "R5");
    burst(10'h005, 1'b1, 1'b0, "R4");
    burst(10'h006, 1'b1, 1'b1, "R6");
    burst(10'h005, 1'b1, 1'b1, "R6");
    // bit 2 set in a short burst
    burst(10'h006, 1'b0, 1'b0, "R7");
    burst(10'h007, 1'b0, 1'b1, "R7");
    // upper bits pass through
    burst(10'h3AB, 1'b1, 1'b0, "R8");
    burst(10'h2D4, 1'b0, 1'b1, "R8");
    // starts during a running burst are dropped
    step(1'b1, 10'h0A5, 1'b1, 1'b0, "R10");
    repeat (5) step(1'b1, 10'h3FF, 1'b0, 1'b1, "R10");
    while (m_v) idle("R10");
    idle("R10");
    // start on the last-beat cycle
    step(1'b1, 10'h102, 1'b0, 1'b0, "R11");
    while (!(m_v && m_last)) idle("R11");
    step(1'b1, 10'h20D, 1'b1, 1'b1, "R11");
    while (!(m_v && m_last)) idle("R11");
    step(1'b1, 10'h0F3, 1'b0, 1'b1, "R11");
    while (m_v) idle("R11");
    idle("R11");
    // mixed random traffic
    for (int k = 0; k < 600; k++)
      step(($urandom % 3) == 0, COL_W'($urandom), 1'($urandom), 1'($urandom), "rand");
    while (m_v) idle("rand");
    idle("rand");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hung run exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule